// File: doc/BRIEF.md
# Packet buffer ownership pool

The pool holds one shared sample RAM cut into four equal buffers of 512 bytes each, that is 256 sixteen-bit words per buffer. A producer streams 16-bit words into the pool. The first word of a packet claims the lowest-numbered free buffer, and the words then fill that buffer in arrival order. When the packet ends, the pool does not move its data. It places a small token, holding only the buffer number and the active length, into a token FIFO that faces the consumer stage.

The consumer pops tokens and reads the buffer contents through a 32-bit port. Each read word is one complex sample: the I word that arrived first sits in the upper half, and the Q word that followed it sits in the lower half. Only the words actually written count, so no padding is kept. When the consumer is done with a buffer, it hands the buffer back with a release strobe. A release of a buffer that is already free is reported on a sticky error flag. When every buffer is owned and no packet is open, the write side stops accepting words and raises a full flag.

Top module: `pkt_pool`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wr_ready`=1, `pool_full`=0, `tok_valid`=0, `rel_err`=0 and `rd_data`=0, and all four buffers are free.
- R2: The first accepted word of a packet (`wr_valid` and `wr_ready` with no packet open) claims the lowest-numbered free buffer. That word is stored at word position 0, and each further word goes to the next position.
- R3: In the cycle after the word with `wr_last` is accepted, a token appears with `tok_id` equal to the buffer number and `tok_len` equal to the number of 16-bit words written. Tokens leave the FIFO in the order in which their packets were completed.
- R4: A packet that reaches 256 words closes at that word even without `wr_last`, and its token has `tok_len`=256. The next accepted word starts a new packet.
- R5: One cycle after `rd_en`, `rd_data` holds bits [31:16] = the word at position 2*`rd_addr` of buffer `rd_id` (I) and bits [15:0] = the word at position 2*`rd_addr`+1 (Q). Without `rd_en`, `rd_data` keeps its value.
- R6: When no buffer is free and no packet is open, `wr_ready`=0 and `pool_full`=1. Words offered then are dropped: they produce no token and claim no buffer.
- R7: A `rel_valid` strobe naming a buffer that is not free returns that buffer to the free list, and the buffer can be claimed from the next cycle on.
- R8: A `rel_valid` strobe naming a buffer that is already free sets `rel_err`, which stays at 1 until reset, and leaves the free list unchanged.
- R9: `tok_pop` while `tok_valid`=1 removes the head token at the clock edge. `tok_pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 16 | Write word (I then Q, alternating) |
| wr_last | input | 1 | Marks the final word of a packet |
| wr_ready | output | 1 | Word is accepted this cycle |
| pool_full | output | 1 | No free buffer and no open packet |
| tok_valid | output | 1 | Token FIFO not empty |
| tok_id | output | 2 | Buffer number of the head token |
| tok_len | output | 9 | Active length of the head token in 16-bit words |
| tok_pop | input | 1 | Removes the head token |
| rd_en | input | 1 | Read strobe |
| rd_id | input | 2 | Buffer to read |
| rd_addr | input | 7 | Pair index inside the buffer |
| rd_data | output | 32 | I/Q pair, I in the upper half |
| rel_valid | input | 1 | Release strobe |
| rel_id | input | 2 | Buffer being returned |
| rel_err | output | 1 | Sticky flag for releasing a free buffer |

## Verification
Every result of the pool is due exactly one clock edge after its cause. A token appears one cycle after its closing word is accepted, read data arrives one cycle after `rd_en`, and both a freed buffer and the error flag take effect one cycle after the release strobe. `wr_ready` and `pool_full` depend only on state registers, so they follow the same one-edge rule. The bench moves a behavioural model on the same rising edge from the same inputs. It compares the model with every output at the falling edge, where the edge's effects have settled and the next stimulus has not yet been applied.

// File: rtl/pkt_pool.sv
module pkt_pool #(
  parameter int NBUF      = 4,
  parameter int BUF_BYTES = 512
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic [15:0]                   wr_data,
  input  logic                          wr_last,
  output logic                          wr_ready,
  output logic                          pool_full,
  output logic                          tok_valid,
  output logic [$clog2(NBUF)-1:0]       tok_id,
  output logic [$clog2(BUF_BYTES/2):0]  tok_len,
  input  logic                          tok_pop,
  input  logic                          rd_en,
  input  logic [$clog2(NBUF)-1:0]       rd_id,
  input  logic [$clog2(BUF_BYTES/4)-1:0] rd_addr,
  output logic [31:0]                   rd_data,
  input  logic                          rel_valid,
  input  logic [$clog2(NBUF)-1:0]       rel_id,
  output logic                          rel_err
);
  localparam int IDW   = $clog2(NBUF);
  localparam int WPB   = BUF_BYTES / 2;
  localparam int CNTW  = $clog2(WPB);
  localparam int LENW  = CNTW + 1;
  localparam int AW    = CNTW - 1;
  localparam int DEPTH = NBUF * (WPB / 2);

  logic [NBUF-1:0] free_q, free_n;
  logic            cur_valid;
  logic [IDW-1:0]  cur_id, alloc_id, wid;
  logic [CNTW-1:0] cur_cnt, wpos;
  logic            wacc, close_pkt, pop_ok;

  logic [15:0] mem_hi [DEPTH];
  logic [15:0] mem_lo [DEPTH];

  logic [IDW-1:0]  tq_id  [NBUF];
  logic [LENW-1:0] tq_len [NBUF];
  logic [IDW-1:0]  head, tail;
  logic [IDW:0]    tcnt;

  always_comb begin
    alloc_id = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (free_q[i]) alloc_id = IDW'(i);
  end

  assign wr_ready  = cur_valid || (|free_q);
  assign pool_full = !wr_ready;
  assign wacc      = wr_valid && wr_ready;
  assign wid       = cur_valid ? cur_id : alloc_id;
  assign wpos      = cur_valid ? cur_cnt : '0;
  assign close_pkt = wacc && (wr_last || wpos == CNTW'(WPB - 1));
  assign pop_ok    = tok_pop && (tcnt != '0);

  always_comb begin
    free_n = free_q;
    if (wacc && !cur_valid) free_n[alloc_id] = 1'b0;
    if (rel_valid && !free_q[rel_id]) free_n[rel_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q    <= '1;
      cur_valid <= 1'b0;
      cur_id    <= '0;
      cur_cnt   <= '0;
      rel_err   <= 1'b0;
      rd_data   <= '0;
    end else begin
      free_q <= free_n;
      if (rel_valid && free_q[rel_id]) rel_err <= 1'b1;
      if (wacc) begin
        cur_valid <= !close_pkt;
        cur_id    <= wid;
        cur_cnt   <= wpos + 1'b1;
      end
      if (rd_en) rd_data <= {mem_hi[{rd_id, rd_addr}], mem_lo[{rd_id, rd_addr}]};
    end
  end

  always_ff @(posedge clk) begin
    if (wacc) begin
      if (!wpos[0]) mem_hi[{wid, wpos[CNTW-1:1]}] <= wr_data;
      else          mem_lo[{wid, wpos[CNTW-1:1]}] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      tcnt <= '0;
    end else begin
      if (close_pkt) begin
        tq_id[tail]  <= wid;
        tq_len[tail] <= LENW'(wpos) + 1'b1;
        tail         <= tail + 1'b1;
      end
      if (pop_ok) head <= head + 1'b1;
      tcnt <= tcnt + (IDW+1)'(close_pkt) - (IDW+1)'(pop_ok);
    end
  end

  assign tok_valid = tcnt != '0;
  assign tok_id    = tq_id[head];
  assign tok_len   = tq_len[head];

  a_r2_alloc_is_free: assert property (@(posedge clk) disable iff (rst)
    (wacc && !cur_valid) |-> free_q[alloc_id]);

  a_r6_ownership_bounded: assert property (@(posedge clk) disable iff (rst)
    ($countones(free_q) + int'(tcnt) + int'(cur_valid)) <= NBUF);

  a_r7_release_frees: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && !free_q[rel_id]) |=> free_q[$past(rel_id)]);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    rel_err |=> rel_err);

  a_r9_pop_empty_noop: assert property (@(posedge clk) disable iff (rst)
    (tok_pop && !tok_valid && !close_pkt) |=> !tok_valid);

  a_r3_token_after_close: assert property (@(posedge clk) disable iff (rst)
    close_pkt |=> tok_valid);
endmodule

// File: tb/sim_pkt_pool.sv
module sim_pkt_pool;
  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_last = 0, tok_pop = 0, rd_en = 0, rel_valid = 0;
  logic [15:0] wr_data = 0;
  logic [1:0] rd_id = 0, rel_id = 0;
  logic [6:0] rd_addr = 0;
  logic wr_ready, pool_full, tok_valid, rel_err;
  logic [1:0] tok_id;
  logic [8:0] tok_len;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  pkt_pool u0 (.clk, .rst, .wr_valid, .wr_data, .wr_last, .wr_ready, .pool_full,
    .tok_valid, .tok_id, .tok_len, .tok_pop, .rd_en, .rd_id, .rd_addr, .rd_data,
    .rel_valid, .rel_id, .rel_err);

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_free [4];
  bit m_cur;
  int m_id, m_cnt;
  int q_id[$], q_len[$];
  bit m_err;
  int m_mem [1024];
  logic [31:0] m_rd;

  function automatic bit m_ready();
    return m_cur || m_free[0] || m_free[1] || m_free[2] || m_free[3];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_free[i]) m_free[i] = 1;
      m_cur = 0; m_id = 0; m_cnt = 0; m_err = 0; m_rd = 0;
      q_id.delete(); q_len.delete();
    end else begin
      bit old [4];
      bit rdy;
      old = m_free;
      rdy = m_ready();
      if (rd_en) m_rd = {m_mem[rd_id*256 + 2*rd_addr][15:0], m_mem[rd_id*256 + 2*rd_addr + 1][15:0]};
      if (tok_pop && q_id.size() > 0) begin
        void'(q_id.pop_front()); void'(q_len.pop_front());
      end
      if (wr_valid && rdy) begin
        int id, pos;
        if (m_cur) begin id = m_id; pos = m_cnt; end
        else begin
          id = 0;
          for (int i = 3; i >= 0; i--) if (old[i]) id = i;
          pos = 0;
          m_free[id] = 0;
        end
        m_mem[id*256 + pos] = int'(wr_data);
        if (wr_last || pos == 255) begin
          q_id.push_back(id); q_len.push_back(pos + 1); m_cur = 0;
        end else begin
          m_cur = 1; m_id = id; m_cnt = pos + 1;
        end
      end
      if (rel_valid) begin
        if (old[rel_id]) m_err = 1;
        else m_free[rel_id] = 1;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 wr_ready", 32'(wr_ready), 32'(m_ready()));
      chk("R6 pool_full", 32'(pool_full), 32'(!m_ready()));
      chk("R3 tok_valid", 32'(tok_valid), 32'(q_id.size() > 0));
      if (q_id.size() > 0) begin
        chk("R3 tok_id", 32'(tok_id), 32'(q_id[0]));
        chk("R3 tok_len", 32'(tok_len), 32'(q_len[0]));
      end
      chk("R8 rel_err", 32'(rel_err), 32'(m_err));
      chk("R5 rd_data", rd_data, m_rd);
    end
  end

  task automatic wr_pkt(int n, int base, bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = 16'(base + i); wr_last = with_last && (i == n - 1);
    end
    @(negedge clk); wr_valid = 0; wr_last = 0;
  endtask

  task automatic rd(int id, int a);
    @(negedge clk); rd_en = 1; rd_id = 2'(id); rd_addr = 7'(a);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rel(int id);
    @(negedge clk); rel_valid = 1; rel_id = 2'(id);
    @(negedge clk); rel_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk); tok_pop = 1;
    @(negedge clk); tok_pop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 tok_valid", 32'(tok_valid), 0);
    chk("R1 rel_err", 32'(rel_err), 0);
    chk("R1 rd_data", rd_data, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 pool_full", 32'(pool_full), 0);

    wr_pkt(6, 16'h1100, 1);
    chk("R2 first id", 32'(tok_id), 0);
    chk("R3 first len", 32'(tok_len), 6);
    wr_pkt(3, 16'h2200, 1);
    rd(0, 0); chk("R5 pair0", rd_data, 32'h1100_1101);
    rd(0, 2); chk("R5 pair2", rd_data, 32'h1104_1105);
    rd(1, 0); chk("R5 buf1", rd_data, 32'h2200_2201);

    wr_pkt(256, 16'h3000, 0);
    wr_pkt(1, 16'h4400, 1);
    chk("R6 full", 32'(pool_full), 1);
    wr_pkt(4, 16'h5500, 1);
    chk("R6 dropped", 32'(wr_ready), 0);

    pop();
    pop();
    chk("R4 len256", 32'(tok_len), 256);
    chk("R4 id", 32'(tok_id), 2);
    rd(2, 127); chk("R4 last pair", rd_data, 32'h30FE_30FF);
    pop();
    chk("R3 order", 32'(tok_id), 3);

    rel(1);
    chk("R7 ready back", 32'(wr_ready), 1);
    rel(2);
    wr_pkt(2, 16'h6600, 1);
    chk("R7 R2 lowest", 32'(tok_id), 3);
    pop();
    chk("R2 reuse id", 32'(tok_id), 1);

    rel(0);
    chk("R8 clean", 32'(rel_err), 0);
    rel(0);
    chk("R8 set", 32'(rel_err), 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", 32'(rel_err), 1);

    pop();
    chk("R9 empty", 32'(tok_valid), 0);
    pop();
    chk("R9 still empty", 32'(tok_valid), 0);
    wr_pkt(2, 16'h7700, 1);
    chk("R9 new head", 32'(tok_id), 0);
    chk("R9 new len", 32'(tok_len), 2);
    rd(1, 0); chk("R5 reused buf", rd_data, 32'h6600_6601);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule